// File: doc/BRIEF.md
# Maskable Alarm Time Comparator

This block keeps one alarm word for each field of a real-time clock: hundredths, hours, minutes, seconds, month, date, year and weekday. It compares those words with the live counter values once per 100 Hz tick. When every field that takes part in the comparison equals its counter, it raises a one-cycle match pulse for the interrupt controller. The counter chain and the routing of interrupts are outside this block.

Each alarm word is eight bits wide. Bit 7 is a "don't care" flag: when it is set, that field is left out of the comparison. The low bits hold the value, and each field has the width of its counter (43 value bits and 8 flags, 51 bits stored in all). In 12-hour mode the hours field carries the PM indicator in bit 4, so AM and PM times compare as different hours. The host writes and reads the words through a small register port that decodes eight consecutive addresses. The tick strobe comes from the counter chain, which updates the counters at the same clock edge that closes the tick cycle.

Top module: `alarm_match_unit`

## Requirements
- R1: After reset every alarm word reads 0x00 and match_o is 0.
- R2: A write with wr_en_i high to an address from 0x08 to 0x0F stores bit 7 and the value bits of that field (hundredths 7 bits at 0x08, hours 5 at 0x09, minutes 6 at 0x0A, seconds 6 at 0x0B, month 4 at 0x0C, date 5 at 0x0D, year 7 at 0x0E, weekday 3 at 0x0F). Reading the word back returns bit 7 and the value bits, and the bits outside the field read as 0.
- R3: A write to an address outside 0x08 to 0x0F, or any cycle with wr_en_i low, leaves every alarm word unchanged.
- R4: When tick_i is high in cycle N and, in cycle N+1, every unmasked field equals its counter input, match_o is high in cycle N+2 and only in that cycle.
- R5: If any unmasked field differs from its counter at the comparison, no pulse is produced for that tick.
- R6: A field whose bit 7 is 1 does not affect the outcome, whatever its value.
- R7: If all eight words have bit 7 set, every tick produces a pulse.
- R8: The hours comparison covers all 5 bits, including the PM indicator in bit 4, so 10 AM (0x0A) does not match 10 PM (0x1A).
- R9: Without a tick no pulse appears, even while all fields match.
- R10: A word written between two ticks is used by the comparison of the next tick.
- R11: rd_data_o shows the word selected by addr_i in the same cycle, and reads as 0x00 for an address outside 0x08 to 0x0F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register address, shared by read and write |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Readback of the addressed alarm word |
| tick_i | input | 1 | 100 Hz tick strobe, one cycle wide |
| hsec_i | input | 7 | Live hundredths counter |
| hour_i | input | 5 | Live hours counter, bit 4 = PM in 12-hour mode |
| min_i | input | 6 | Live minutes counter |
| sec_i | input | 6 | Live seconds counter |
| month_i | input | 4 | Live month counter |
| date_i | input | 5 | Live date counter |
| year_i | input | 7 | Live year counter |
| wday_i | input | 3 | Live weekday counter |
| match_o | output | 1 | One-cycle alarm match pulse |

## Verification
The condition that is hardest to create is a full eight-field match that fails on one unmasked field alone: a single wrong bit, such as the PM indicator in the hours field. To reach it, the stimulus first loads a complete alarm time and shows that it matches. It then moves one field at a time (seconds off by one, then the hour changed only in bit 4) and ticks after each change. It also sets the flag of the broken field to show that masking restores the match. A word is also rewritten between two ticks to show that the next comparison uses the new value.

// File: rtl/alarm_cmp_pkg.sv
package alarm_cmp_pkg;
  localparam int NUM_FIELDS = 8;
  localparam int WORD_W     = 8;
  localparam int VAL_W      = WORD_W - 1;
  localparam int MASK_BIT   = WORD_W - 1;

  typedef enum logic [2:0] {
    F_HSEC  = 3'd0,
    F_HOUR  = 3'd1,
    F_MIN   = 3'd2,
    F_SEC   = 3'd3,
    F_MONTH = 3'd4,
    F_DATE  = 3'd5,
    F_YEAR  = 3'd6,
    F_WDAY  = 3'd7
  } field_e;

  localparam int HSEC_W  = 7;
  localparam int HOUR_W  = 5;
  localparam int MIN_W   = 6;
  localparam int SEC_W   = 6;
  localparam int MONTH_W = 4;
  localparam int DATE_W  = 5;
  localparam int YEAR_W  = 7;
  localparam int WDAY_W  = 3;

  function automatic int field_width(input int idx);
    case (idx)
      0: return HSEC_W;
      1: return HOUR_W;
      2: return MIN_W;
      3: return SEC_W;
      4: return MONTH_W;
      5: return DATE_W;
      6: return YEAR_W;
      default: return WDAY_W;
    endcase
  endfunction

  // bits kept on a write: flag plus value bits of the field
  function automatic logic [WORD_W-1:0] field_keep(input int idx);
    logic [WORD_W-1:0] k;
    k = '0;
    for (int b = 0; b < VAL_W; b++) k[b] = (b < field_width(idx));
    k[MASK_BIT] = 1'b1;
    return k;
  endfunction

  typedef logic [NUM_FIELDS-1:0][WORD_W-1:0] word_bank_t;
endpackage

// File: rtl/alarm_word_bank.sv
module alarm_word_bank
  import alarm_cmp_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int BASE_ADDR = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [WORD_W-1:0] rd_data_o,
  output word_bank_t        word_o
);
  localparam int SEL_W = $clog2(NUM_FIELDS);

  logic [ADDR_W-1:0] offset;
  logic              in_range;
  logic [SEL_W-1:0]  sel;
  logic              unused_offset_hi;

  assign offset   = addr_i - ADDR_W'(BASE_ADDR);
  assign in_range = (addr_i >= ADDR_W'(BASE_ADDR)) && (offset < ADDR_W'(NUM_FIELDS));
  assign sel      = offset[SEL_W-1:0];
  assign unused_offset_hi = ^offset[ADDR_W-1:SEL_W];

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_word
    localparam logic [WORD_W-1:0] KEEP = field_keep(i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        word_o[i] <= '0;
      end else if (wr_en_i && in_range && (sel == SEL_W'(i))) begin
        word_o[i] <= wr_data_i & KEEP;
      end
    end
  end

  assign rd_data_o = in_range ? word_o[sel] : '0;
endmodule

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp
  import alarm_cmp_pkg::*;
#(
  parameter int FW = 7
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [VAL_W-1:0]  live_i,
  output logic              hit_o
);
  localparam logic [VAL_W-1:0] VAL_KEEP = VAL_W'((1 << FW) - 1);

  logic equal;
  assign equal = ((word_i[VAL_W-1:0] & VAL_KEEP) == (live_i & VAL_KEEP));
  // flag set = field is don't care
  assign hit_o = word_i[MASK_BIT] | equal;
endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit
  import alarm_cmp_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int BASE_ADDR = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [WORD_W-1:0] rd_data_o,
  input  logic              tick_i,
  input  logic [HSEC_W-1:0]  hsec_i,
  input  logic [HOUR_W-1:0]  hour_i,
  input  logic [MIN_W-1:0]   min_i,
  input  logic [SEC_W-1:0]   sec_i,
  input  logic [MONTH_W-1:0] month_i,
  input  logic [DATE_W-1:0]  date_i,
  input  logic [YEAR_W-1:0]  year_i,
  input  logic [WDAY_W-1:0]  wday_i,
  output logic              match_o
);
  word_bank_t                          word_q;
  logic [NUM_FIELDS-1:0][VAL_W-1:0]    live_v;
  logic [NUM_FIELDS-1:0]               hit;
  logic [NUM_FIELDS-1:0]               mask_vec;
  logic                                tick_q;
  logic                                match_q;

  alarm_word_bank #(
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR)
  ) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o),
    .word_o   (word_q)
  );

  assign live_v[F_HSEC]  = VAL_W'(hsec_i);
  assign live_v[F_HOUR]  = VAL_W'(hour_i);
  assign live_v[F_MIN]   = VAL_W'(min_i);
  assign live_v[F_SEC]   = VAL_W'(sec_i);
  assign live_v[F_MONTH] = VAL_W'(month_i);
  assign live_v[F_DATE]  = VAL_W'(date_i);
  assign live_v[F_YEAR]  = VAL_W'(year_i);
  assign live_v[F_WDAY]  = VAL_W'(wday_i);

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_cmp
    alarm_field_cmp #(.FW(field_width(i))) u_cmp (
      .word_i(word_q[i]),
      .live_i(live_v[i]),
      .hit_o (hit[i])
    );
    assign mask_vec[i] = word_q[i][MASK_BIT];
  end

  // tick_q marks the cycle in which the counters hold the new time
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q  <= 1'b0;
      match_q <= 1'b0;
    end else begin
      tick_q  <= tick_i;
      match_q <= tick_q & (&hit);
    end
  end

  assign match_o = match_q;
endmodule

// File: rtl/alarm_match_checker.sv
module alarm_match_checker
  import alarm_cmp_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int BASE_ADDR = 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  wr_en_i,
  input logic [ADDR_W-1:0]     addr_i,
  input logic [WORD_W-1:0]     rd_data_o,
  input logic                  tick_i,
  input logic                  match_o,
  input logic [NUM_FIELDS-1:0] mask_vec,
  input word_bank_t            word_q
);
  a_r4_pulse_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> $past(tick_i, 2));

  a_r4_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && !$past(tick_i)) |=> !match_o);

  a_r7_all_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(tick_i) && (&mask_vec)) |=> match_o);

  a_r3_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(word_q));

  a_r11_outside_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((addr_i < ADDR_W'(BASE_ADDR)) || (addr_i >= ADDR_W'(BASE_ADDR + NUM_FIELDS)))
      |-> (rd_data_o == '0));
endmodule

bind alarm_match_unit alarm_match_checker #(
  .ADDR_W   (ADDR_W),
  .BASE_ADDR(BASE_ADDR)
) i_alarm_match_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .addr_i   (addr_i),
  .rd_data_o(rd_data_o),
  .tick_i   (tick_i),
  .match_o  (match_o),
  .mask_vec (mask_vec),
  .word_q   (word_q)
);

// File: tb/test_alarm_match_unit.sv
module test_alarm_match_unit;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [4:0] addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_data_o;
  logic       tick_i = 1'b0;
  logic [6:0] hsec_i = '0;
  logic [4:0] hour_i = '0;
  logic [5:0] min_i = '0;
  logic [5:0] sec_i = '0;
  logic [3:0] month_i = '0;
  logic [4:0] date_i = '0;
  logic [6:0] year_i = '0;
  logic [2:0] wday_i = '0;
  logic       match_o;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    int    due;
    bit    exp;
    string tag;
  } item_t;
  item_t sb[$];

  alarm_match_unit i_alarm_match_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .tick_i(tick_i),
    .hsec_i(hsec_i), .hour_i(hour_i), .min_i(min_i), .sec_i(sec_i),
    .month_i(month_i), .date_i(date_i), .year_i(year_i), .wday_i(wday_i),
    .match_o(match_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected pulse outcomes, flags any stray pulse
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      if (sb.size() > 0 && sb[0].due == cyc) begin
        item_t it;
        it = sb.pop_front();
        check(it.tag, int'(match_o), int'(it.exp));
      end else if (match_o !== 1'b0) begin
        check("R4/R9 stray pulse", int'(match_o), 0);
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [7:0] d, input logic en = 1'b1);
    @(negedge clk_i);
    wr_en_i = en; addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd_check(input logic [4:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk_i);
    addr_i = a;
    #1;
    check(tag, int'(rd_data_o), int'(exp));
  endtask

  task automatic set_time(input logic [6:0] hs, input logic [4:0] hr, input logic [5:0] mi,
                          input logic [5:0] se, input logic [3:0] mo, input logic [4:0] da,
                          input logic [6:0] yr, input logic [2:0] wd);
    @(negedge clk_i);
    hsec_i = hs; hour_i = hr; min_i = mi; sec_i = se;
    month_i = mo; date_i = da; year_i = yr; wday_i = wd;
  endtask

  // tick in cycle N, pulse expected in cycle N+2
  task automatic do_tick(input bit exp, input string tag);
    item_t it;
    @(negedge clk_i);
    tick_i = 1'b1;
    it.due = cyc + 2; it.exp = exp; it.tag = tag;
    sb.push_back(it);
    @(negedge clk_i);
    tick_i = 1'b0;
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  localparam logic [7:0] FULL [8] = '{8'hFF, 8'h9F, 8'hBF, 8'hBF, 8'h8F, 8'h9F, 8'hFF, 8'h87};

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1
    for (int i = 0; i < 8; i++) rd_check(5'(8 + i), 8'h00, "R1 reset word");
    check("R1 reset match_o", int'(match_o), 0);

    // R2: unused bits drop, flag and value bits kept
    for (int i = 0; i < 8; i++) wr(5'(8 + i), 8'hFF);
    for (int i = 0; i < 8; i++) rd_check(5'(8 + i), FULL[i], "R2 readback");

    // R7: all masked, any time matches
    set_time(7'd3, 5'd7, 6'd1, 6'd2, 4'd9, 5'd4, 7'd50, 3'd1);
    do_tick(1'b1, "R7 all masked tick 1");
    set_time(7'd4, 5'd7, 6'd1, 6'd2, 4'd9, 5'd4, 7'd50, 3'd1);
    do_tick(1'b1, "R7 all masked tick 2");

    // R9: no tick, no pulse
    repeat (6) begin
      @(negedge clk_i);
      check("R9 idle no pulse", int'(match_o), 0);
    end

    // R3: ignored writes
    wr(5'h07, 8'h00);
    wr(5'h10, 8'h00);
    wr(5'h1F, 8'h00);
    wr(5'h08, 8'h00, 1'b0);
    for (int i = 0; i < 8; i++) rd_check(5'(8 + i), FULL[i], "R3 word unchanged");
    // R11
    rd_check(5'h07, 8'h00, "R11 below range");
    rd_check(5'h10, 8'h00, "R11 above range");
    rd_check(5'h0D, 8'h9F, "R11 same-cycle readback");

    // R4: full unmasked match
    wr(5'h08, 8'd25); wr(5'h09, 8'h0A); wr(5'h0A, 8'd30); wr(5'h0B, 8'd45);
    wr(5'h0C, 8'd6);  wr(5'h0D, 8'd15); wr(5'h0E, 8'd24); wr(5'h0F, 8'd3);
    set_time(7'd25, 5'h0A, 6'd30, 6'd45, 4'd6, 5'd15, 7'd24, 3'd3);
    do_tick(1'b1, "R4 full match");
    // R5
    set_time(7'd25, 5'h0A, 6'd30, 6'd46, 4'd6, 5'd15, 7'd24, 3'd3);
    do_tick(1'b0, "R5 seconds differ");
    set_time(7'd25, 5'h0A, 6'd30, 6'd45, 4'd6, 5'd15, 7'd24, 3'd2);
    do_tick(1'b0, "R5 weekday differs");
    // R6
    wr(5'h0F, 8'h83);
    do_tick(1'b1, "R6 weekday masked");
    // R8: PM bit
    wr(5'h0F, 8'd3);
    set_time(7'd25, 5'h1A, 6'd30, 6'd45, 4'd6, 5'd15, 7'd24, 3'd3);
    do_tick(1'b0, "R8 PM vs AM");
    wr(5'h09, 8'h1A);
    do_tick(1'b1, "R8 PM matches PM");
    // R10
    wr(5'h08, 8'd26);
    do_tick(1'b0, "R10 new alarm value used");
    set_time(7'd26, 5'h1A, 6'd30, 6'd45, 4'd6, 5'd15, 7'd24, 3'd3);
    do_tick(1'b1, "R10 matches new value");

    repeat (4) @(negedge clk_i);
    check("R4 scoreboard drained", sb.size(), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule